// File: doc/BRIEF.md
# Per-Line Data Standard Scheduler for Vertical Blanking

This block follows the line position inside each video field and tells a downstream data slicer which of sixteen data standards to decode on the line now being processed. A falling edge of the horizontal reference strobe, delayed by a programmable horizontal offset, marks the start of each line. A falling edge of the vertical strobe, followed by a programmable number of line starts, resets the line count to line 1. A field-identifier input, optionally inverted by a field-offset bit, chooses between two per-field codes.

Software loads 23 selection bytes through a plain address, data and write-strobe port, one byte per line from line 2 to line 24. The lower nibble of each byte is the standard for the first field and the upper nibble is the standard for the second field. The code for line 24 stays in force for every later line of the field. So an all-ones nibble there switches the slicer off through active video. The slicer enable is low whenever the code in force is 1111b.

Top module: `vbi_line_sched`

## Requirements
- R1: After reset, std_code is 1111b, slicer_en is 0 and line_start is 0. All selection bytes reset to FFh.
- R2: The first clock edge that samples href low, after it was sampled high, starts a timer. line_start is high for exactly one cycle, during the cycle after clock edge hoff+3, where edge 1 is the edge that sampled href low.
- R3: After a falling edge of vref, the first voff line starts continue the old count. The line start after those is line 1. Each later line start adds one to the line number.
- R4: For line n from 2 to 24, the code is taken from the selection byte at address 41h+(n-2).
- R5: The field in force is latched at the line-1 start as field_id XOR foff. A value of 0 means the first field and selects bits [3:0]. A value of 1 means the second field and selects bits [7:4].
- R6: The line count stops at 25. Every line after line 24 in a field uses the line-24 byte.
- R7: The code is 1111b on line 1 and before the first vertical event. slicer_en equals (std_code != 1111b).
- R8: A write with cfg_addr outside 41h..57h changes no selection byte.
- R9: std_code and slicer_en change only in a cycle where line_start is high. A byte written between line starts takes effect at the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| href | input | 1 | Horizontal reference strobe; its falling edge is the line reference |
| vref | input | 1 | Vertical strobe; its falling edge is the field reference |
| field_id | input | 1 | Field identifier from the decoder |
| hoff | input | HOFF_W (11) | Clocks from the href falling edge to the line trigger |
| voff | input | VOFF_W (9) | Line starts skipped after the vref falling edge before line 1 |
| foff | input | 1 | Inverts field_id when the field is chosen |
| cfg_we | input | 1 | Selection-byte write strobe |
| cfg_addr | input | ADDR_W (8) | Selection-byte address |
| cfg_wdata | input | 8 | Selection-byte write data |
| std_code | output | 4 | Standard code for the current line |
| slicer_en | output | 1 | Slicer enable, low for code 1111b |
| line_start | output | 1 | One-cycle pulse at each line start |

## Verification
The assertions check on every cycle that:
- a line trigger never lasts two cycles;
- the line count never passes 25;
- a field restart always lands on line 1;
- the latched field holds between restarts;
- out-of-range writes leave the byte bank untouched;
- the enable matches the code;
- the code moves only with a line-start pulse.

Only the bench scenarios can show the exact trigger latency for a given offset, and which byte and nibble are used on each line of fields with different field, offset and vertical-skip settings. They also show the line-24 code held past line 24, and a mid-field write that waits for the next line start.

// File: rtl/vbi_sched_pkg.sv
package vbi_sched_pkg;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_OFF = 4'hF;

  // Nibble choice: first field takes bits [3:0], second field bits [7:4].
  function automatic logic [CODE_W-1:0] pick_code(input logic [7:0] sel_byte,
                                                   input logic second_field);
    return second_field ? sel_byte[7:4] : sel_byte[3:0];
  endfunction

  // Enable rule applied to a code.
  function automatic logic code_active(input logic [CODE_W-1:0] code);
    return code != CODE_OFF;
  endfunction

endpackage

// File: rtl/vbi_htrig.sv
module vbi_htrig #(
  parameter int HOFF_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href,
  input  logic [HOFF_W-1:0] hoff,
  output logic              h_trig
);

  logic              href_q;
  logic              armed;
  logic [HOFF_W-1:0] hcnt;
  logic              h_fall;

  assign h_fall = href_q & ~href;
  assign h_trig = armed && (hcnt == hoff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      href_q <= 1'b0;
      armed  <= 1'b0;
      hcnt   <= '0;
    end else begin
      href_q <= href;
      if (h_fall) begin
        armed <= 1'b1;
        hcnt  <= '0;
      end else if (h_trig) begin
        armed <= 1'b0;
      end else if (armed) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R2: a line trigger is a single-cycle event
  p_trig_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_trig |=> !h_trig);

endmodule

// File: rtl/vbi_line_track.sv
module vbi_line_track #(
  parameter int VOFF_W    = 9,
  parameter int LAST_LINE = 24,
  parameter int LINE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vref,
  input  logic              field_id,
  input  logic              foff,
  input  logic [VOFF_W-1:0] voff,
  input  logic              h_trig,
  output logic [LINE_W-1:0] line_no,
  output logic              second_field
);

  localparam logic [LINE_W-1:0] LINE_SAT = LINE_W'(LAST_LINE + 1);

  logic              vref_q;
  logic              pend;
  logic [VOFF_W-1:0] vwait;
  logic              v_fall;
  logic              restart;
  logic              advance;

  assign v_fall  = vref_q & ~vref;
  assign restart = h_trig && pend && (vwait == '0) && !v_fall;
  assign advance = h_trig && !restart && !v_fall &&
                   (line_no != '0) && (line_no != LINE_SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vref_q       <= 1'b0;
      pend         <= 1'b0;
      vwait        <= '0;
      line_no      <= '0;
      second_field <= 1'b0;
    end else begin
      vref_q <= vref;
      if (v_fall) begin
        pend  <= 1'b1;
        vwait <= voff;
      end else if (restart) begin
        pend         <= 1'b0;
        line_no      <= LINE_W'(1);
        second_field <= field_id ^ foff;
      end else if (h_trig && pend) begin
        vwait <= vwait - 1'b1;
      end
      if (advance) line_no <= line_no + 1'b1;
    end
  end

  // R6: the line count never passes the saturation point
  p_line_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_no <= LINE_SAT);

  // R3: a field restart lands on line 1
  p_restart_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (line_no == LINE_W'(1)));

  // R5: the field choice only moves at a restart
  p_field_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(second_field));

endmodule

// File: rtl/vbi_sel_bank.sv
module vbi_sel_bank
  import vbi_sched_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h41,
  parameter int              FIRST_LINE = 2,
  parameter int              LAST_LINE  = 24,
  parameter int              LINE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [LINE_W-1:0] line_no,
  input  logic              second_field,
  output logic [CODE_W-1:0] code_now
);

  localparam int SLOTS  = LAST_LINE - FIRST_LINE + 1;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [7:0]         bank [SLOTS];
  logic [SLOTS*8-1:0] bank_flat;
  logic [ADDR_W-1:0]  wr_off;
  logic               wr_hit;
  logic [SLOT_W-1:0]  wr_slot;

  assign wr_off  = cfg_addr - BASE_ADDR;
  assign wr_hit  = cfg_we && (cfg_addr >= BASE_ADDR) && (wr_off < ADDR_W'(SLOTS));
  assign wr_slot = wr_off[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) bank[i] <= 8'hFF;
    end else if (wr_hit) begin
      bank[wr_slot] <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign bank_flat[g*8 +: 8] = bank[g];
  end

  // Lines past the last one reuse the last line's slot.
  function automatic logic [SLOT_W-1:0] line_slot(input logic [LINE_W-1:0] ln);
    logic [LINE_W-1:0] clamped;
    clamped = (ln > LINE_W'(LAST_LINE)) ? LINE_W'(LAST_LINE) : ln;
    return SLOT_W'(clamped - LINE_W'(FIRST_LINE));
  endfunction

  always_comb begin
    if (line_no < LINE_W'(FIRST_LINE)) code_now = CODE_OFF;
    else code_now = pick_code(bank[line_slot(line_no)], second_field);
  end

  // R8: writes outside the window leave every byte alone
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_hit) |=> $stable(bank_flat));

endmodule

// File: rtl/vbi_line_sched.sv
module vbi_line_sched
  import vbi_sched_pkg::*;
#(
  parameter int                HOFF_W     = 11,
  parameter int                VOFF_W     = 9,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h41,
  parameter int                FIRST_LINE = 2,
  parameter int                LAST_LINE  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href,
  input  logic              vref,
  input  logic              field_id,
  input  logic [HOFF_W-1:0] hoff,
  input  logic [VOFF_W-1:0] voff,
  input  logic              foff,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [3:0]        std_code,
  output logic              slicer_en,
  output logic              line_start
);

  localparam int LINE_W = $clog2(LAST_LINE + 2);

  logic              h_trig;
  logic              trig_q;
  logic [LINE_W-1:0] cur_line;
  logic              cur_second;
  logic [CODE_W-1:0] code_now;

  vbi_htrig #(.HOFF_W(HOFF_W)) u_htrig (
    .clk    (clk),
    .rst_n  (rst_n),
    .href   (href),
    .hoff   (hoff),
    .h_trig (h_trig)
  );

  vbi_line_track #(
    .VOFF_W    (VOFF_W),
    .LAST_LINE (LAST_LINE),
    .LINE_W    (LINE_W)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .vref         (vref),
    .field_id     (field_id),
    .foff         (foff),
    .voff         (voff),
    .h_trig       (h_trig),
    .line_no      (cur_line),
    .second_field (cur_second)
  );

  vbi_sel_bank #(
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .FIRST_LINE (FIRST_LINE),
    .LAST_LINE  (LAST_LINE),
    .LINE_W     (LINE_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .line_no      (cur_line),
    .second_field (cur_second),
    .code_now     (code_now)
  );

  // The line number settles one cycle after the trigger; the outputs are
  // loaded one cycle later still, together with the pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q     <= 1'b0;
      line_start <= 1'b0;
      std_code   <= CODE_OFF;
      slicer_en  <= 1'b0;
    end else begin
      trig_q     <= h_trig;
      line_start <= trig_q;
      if (trig_q) begin
        std_code  <= code_now;
        slicer_en <= code_active(code_now);
      end
    end
  end

  // R9: the code only moves together with a line-start pulse
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |-> $stable(std_code));

  // R7: the enable follows the code in force
  p_en_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slicer_en == (std_code != CODE_OFF));

  // R7: line 1 and the pre-vertical state carry the off code
  p_line1_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && (cur_line <= LINE_W'(1))) |-> (std_code == CODE_OFF));

endmodule

// File: tb/vbi_line_sched_test.sv
module vbi_line_sched_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        href, vref, field_id, foff, cfg_we;
  logic [10:0] hoff;
  logic [8:0]  voff;
  logic [7:0]  cfg_addr, cfg_wdata;
  logic [3:0]  std_code;
  logic        slicer_en, line_start;

  always #5 clk = ~clk;

  vbi_line_sched uut (
    .clk(clk), .rst_n(rst_n), .href(href), .vref(vref), .field_id(field_id),
    .hoff(hoff), .voff(voff), .foff(foff), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .std_code(std_code), .slicer_en(slicer_en),
    .line_start(line_start)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] shadow [23];

  // Out-of-range and overriding writes: {addr, data}
  localparam logic [15:0] WR_TAB [6] = '{16'h4000, 16'h5800, 16'h57F3,
                                         16'h412A, 16'hFF11, 16'h0022};
  // Field scenarios: {field_id, foff, hoff[10:0], voff[8:0], inject}
  localparam logic [22:0] FIELD_TAB [4] = '{
    {1'b0, 1'b0, 11'd5, 9'd2, 1'b0},
    {1'b1, 1'b0, 11'd3, 9'd1, 1'b0},
    {1'b1, 1'b1, 11'd0, 9'd0, 1'b1},
    {1'b0, 1'b1, 11'd7, 9'd3, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int ln, input bit second);
    int l;
    if (ln < 2) return 15;
    l = (ln > 24) ? 24 : ln;
    return second ? int'(shadow[l-2][7:4]) : int'(shadow[l-2][3:0]);
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8'h41 && a <= 8'h57) shadow[a - 8'h41] = d;  // R8 model
  endtask

  task automatic pulse_line(input int hofs, output int code, output int en);
    int lat = 0;
    @(negedge clk);
    href = 1'b0;
    while (lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (line_start) break;
    end
    check("R2 trigger latency", lat, hofs + 3);
    code = int'(std_code);
    en   = int'(slicer_en);
    @(negedge clk);
    check("R2 single-cycle pulse", int'(line_start), 0);
    href = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_field(input logic [22:0] sc);
    int code, en, hofs, vofs, e;
    bit second;
    field_id = sc[22]; foff = sc[21];
    hofs = int'(sc[20:10]); vofs = int'(sc[9:1]);
    hoff = sc[20:10]; voff = sc[9:1];
    second = sc[22] ^ sc[21];
    @(negedge clk); vref = 1'b1;
    repeat (2) @(negedge clk); vref = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < vofs; k++) pulse_line(hofs, code, en);
    for (int ln = 1; ln <= 27; ln++) begin
      pulse_line(hofs, code, en);
      e = exp_code(ln, second);
      if (ln == 1)      check("R3 line 1 off code", code, e);
      else if (ln <= 24) check("R4/R5 line code", code, e);
      else               check("R6 held line-24 code", code, e);
      check("R7 enable", en, (e != 15) ? 1 : 0);
      if (sc[0] && ln == 4) begin
        cfg_write(8'h44, 8'h77);
        for (int w = 0; w < 4; w++) begin
          @(negedge clk);
          check("R9 code held until next line start", int'(std_code), code);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int code, en;
    rst_n = 1'b0; href = 1'b1; vref = 1'b1; field_id = 1'b0; foff = 1'b0;
    hoff = 11'd4; voff = 9'd0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < 23; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset code", int'(std_code), 15);
    check("R1 reset enable", int'(slicer_en), 0);
    check("R1 reset pulse", int'(line_start), 0);

    // R7: no vertical event yet, so the code is off
    pulse_line(4, code, en);
    check("R7 pre-vertical code", code, 15);
    check("R7 pre-vertical enable", en, 0);

    for (int i = 0; i < 23; i++) begin
      logic [3:0] hi = 4'((i + 5) % 15);
      logic [3:0] lo = 4'((i % 14) + 1);
      cfg_write(8'(8'h41 + i), {hi, lo});
    end
    for (int t = 0; t < 6; t++) cfg_write(WR_TAB[t][15:8], WR_TAB[t][7:0]);

    for (int f = 0; f < 4; f++) run_field(FIELD_TAB[f]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule